// File: doc/BRIEF.md
# DPLL Mode Controller and Frequency Core

This block is the frequency-computing heart of a telecom timing loop. Once per frame it takes a signed phase error from an upstream phase detector. It clamps that error so the loop can never slew faster than a fixed step per frame. It then passes the clamped error through a proportional-plus-integral filter, and the result is the frequency word that drives the downstream oscillator and synthesis paths.

The block also decides the operating mode. A free-run request from the reference controller takes precedence over everything else. A reference-switch request or an impairment flag puts the loop into holdover. In holdover the frequency word is frozen to the mean of a window of past per-frame frequency samples. That window skips the newest few samples, so the transient that caused the switch is not part of the average. If no full history exists yet, a holdover request falls back to free-run, which outputs the nominal centre word. On return to normal tracking, the integrator is loaded with the current word, so the output frequency does not step.

Top module: `dpll_mode_core`

## Requirements
- R1: After reset, mode_o is 2 (free-run) and freq_word_o equals the nominal word NOMINAL (default 2^27).
- R2: Mode encoding is 0 normal, 1 holdover, 2 free-run. freerun_req_i overrides ref_switch_i and impair_i, and either of those two overrides normal. mode_o reflects the inputs one clock edge after they are applied.
- R3: A holdover request while the history holds fewer than GUARD+AVG_N samples yields free-run (mode 2) instead of holdover.
- R4: The phase error is clamped to the range -STEP_MAX..+STEP_MAX (default 5) before filtering.
- R5: In normal mode, each frame_tick_i updates the state at the same edge. The integrator becomes integ + (lim << KI_SHIFT), and freq_word_o becomes that new integrator value plus (lim << KP_SHIFT), where lim is the clamped error.
- R6: In normal mode without frame_tick_i, freq_word_o does not change.
- R7: Each normal-mode tick stores the word freq_word_o showed before that tick into the history, newest first. In holdover, freq_word_o is the floor mean of the AVG_N samples that lie behind the newest GUARD samples (defaults AVG_N=4, GUARD=2).
- R8: In free-run, freq_word_o equals NOMINAL.
- R9: On entry to normal mode the integrator is loaded with freq_word_o, so a zero-error first tick leaves the word unchanged.
- R10: Outside normal mode, neither the integrator nor the history changes, and frame ticks have no effect on them.
- R11: freq_word_o follows a mode change one clock edge after mode_o does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_tick_i | input | 1 | One-cycle pulse per frame; qualifies phase_err_i |
| phase_err_i | input | ERR_W | Signed phase error from the detector |
| freerun_req_i | input | 1 | Force free-run |
| ref_switch_i | input | 1 | Reference switch in progress; requests holdover |
| impair_i | input | 1 | Reference impaired; requests holdover |
| freq_word_o | output | FREQ_W | Frequency word to the oscillator |
| mode_o | output | 2 | Current mode (0 normal, 1 holdover, 2 free-run) |

## Verification
A filter update caused by a tick appears on freq_word_o at the clock edge that samples the tick. A mode request appears on mode_o after one edge, and the matching frequency word (holdover average, nominal value, or an unchanged word on entry to normal) appears after a second edge. The bench applies every stimulus on the falling edge. It waits exactly one falling edge before checking a tick result, and two falling edges before checking the word after a mode change, with mode_o checked at the first of those. A bench-side model keeps its own integrator, history and mode, and updates them at those same points.

// File: rtl/dpll_pkg.sv
package dpll_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_HOLD   = 2'd1,
    MODE_FREE   = 2'd2
  } mode_e;
endpackage

// File: rtl/dpll_slope_limit.sv
module dpll_slope_limit #(
  parameter int ERR_W    = 16,
  parameter int STEP_MAX = 5
) (
  input  logic signed [ERR_W-1:0] err_i,
  output logic signed [ERR_W-1:0] lim_o
);
  localparam logic signed [ERR_W-1:0] HI = ERR_W'(STEP_MAX);
  localparam logic signed [ERR_W-1:0] LO = -HI;

  always_comb begin
    if (err_i > HI)      lim_o = HI;
    else if (err_i < LO) lim_o = LO;
    else                 lim_o = err_i;
  end
endmodule

// File: rtl/dpll_mode_sel.sv
module dpll_mode_sel
  import dpll_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  freerun_req_i,
  input  logic  hold_req_i,
  input  logic  hist_valid_i,
  output mode_e mode_o,
  output logic  enter_normal_o
);
  mode_e mode_d, mode_q;

  always_comb begin
    if (freerun_req_i)   mode_d = MODE_FREE;
    else if (hold_req_i) mode_d = hist_valid_i ? MODE_HOLD : MODE_FREE;
    else                 mode_d = MODE_NORMAL;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) mode_q <= MODE_FREE;
    else         mode_q <= mode_d;

  assign mode_o         = mode_q;
  assign enter_normal_o = (mode_q != MODE_NORMAL) && (mode_d == MODE_NORMAL);

  p_freerun_prio_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freerun_req_i |=> mode_q == MODE_FREE);
  p_hold_needs_hist_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_req_i && !freerun_req_i && !hist_valid_i) |=> mode_q == MODE_FREE);
endmodule

// File: rtl/dpll_freq_hist.sv
module dpll_freq_hist #(
  parameter int FREQ_W    = 28,
  parameter int AVG_N_LOG = 2,
  parameter int GUARD     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [FREQ_W-1:0] sample_i,
  output logic [FREQ_W-1:0] avg_o,
  output logic              valid_o
);
  localparam int AVG_N = 1 << AVG_N_LOG;
  localparam int DEPTH = GUARD + AVG_N;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int SUM_W = FREQ_W + AVG_N_LOG;

  logic [FREQ_W-1:0] dl_q [DEPTH];
  logic [CNT_W-1:0]  fill_q;
  logic [SUM_W-1:0]  sum;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) dl_q[0] <= '0;
    else if (wr_i) dl_q[0] <= sample_i;

  for (genvar k = 1; k < DEPTH; k++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) dl_q[k] <= '0;
      else if (wr_i) dl_q[k] <= dl_q[k-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) fill_q <= '0;
    else if (wr_i && fill_q != CNT_W'(DEPTH)) fill_q <= fill_q + 1'b1;

  // newest GUARD taps skipped: they carry the switching transient
  always_comb begin
    sum = '0;
    for (int k = GUARD; k < DEPTH; k++) sum = sum + SUM_W'(dl_q[k]);
  end

  assign avg_o   = FREQ_W'(sum >> AVG_N_LOG);
  assign valid_o = (fill_q == CNT_W'(DEPTH));

  p_hist_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(sum));
endmodule

// File: rtl/dpll_loop_filter.sv
module dpll_loop_filter
  import dpll_pkg::*;
#(
  parameter int                ERR_W    = 16,
  parameter int                FREQ_W   = 28,
  parameter int                KP_SHIFT = 4,
  parameter int                KI_SHIFT = 1,
  parameter logic [FREQ_W-1:0] NOMINAL  = FREQ_W'(1) << (FREQ_W - 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  mode_e                   mode_i,
  input  logic                    tick_i,
  input  logic                    preload_i,
  input  logic signed [ERR_W-1:0] lim_i,
  input  logic [FREQ_W-1:0]       hold_avg_i,
  output logic [FREQ_W-1:0]       freq_o
);
  logic [FREQ_W-1:0] integ_q, freq_q, lim_ext, integ_nx, prop;

  assign lim_ext  = {{(FREQ_W-ERR_W){lim_i[ERR_W-1]}}, lim_i};
  assign integ_nx = integ_q + (lim_ext << KI_SHIFT);
  assign prop     = lim_ext << KP_SHIFT;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                                  integ_q <= NOMINAL;
    else if (preload_i)                           integ_q <= freq_q;
    else if (mode_i == MODE_NORMAL && tick_i)     integ_q <= integ_nx;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) freq_q <= NOMINAL;
    else begin
      unique case (mode_i)
        MODE_NORMAL: if (tick_i) freq_q <= integ_nx + prop;
        MODE_HOLD:   freq_q <= hold_avg_i;
        default:     freq_q <= NOMINAL;
      endcase
    end

  assign freq_o = freq_q;

  p_no_tick_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_NORMAL && !tick_i) |=> $stable(freq_q));
  p_free_nominal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_FREE) |=> freq_q == NOMINAL);
  p_integ_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MODE_NORMAL && !preload_i) |=> $stable(integ_q));
endmodule

// File: rtl/dpll_mode_core.sv
module dpll_mode_core
  import dpll_pkg::*;
#(
  parameter int                ERR_W     = 16,
  parameter int                FREQ_W    = 28,
  parameter int                STEP_MAX  = 5,
  parameter int                KP_SHIFT  = 4,
  parameter int                KI_SHIFT  = 1,
  parameter int                AVG_N_LOG = 2,
  parameter int                GUARD     = 2,
  parameter logic [FREQ_W-1:0] NOMINAL   = FREQ_W'(1) << (FREQ_W - 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    frame_tick_i,
  input  logic signed [ERR_W-1:0] phase_err_i,
  input  logic                    freerun_req_i,
  input  logic                    ref_switch_i,
  input  logic                    impair_i,
  output logic [FREQ_W-1:0]       freq_word_o,
  output logic [1:0]              mode_o
);
  logic signed [ERR_W-1:0] lim;
  logic [FREQ_W-1:0]       hold_avg, freq;
  logic                    hist_valid, enter_normal, hist_wr;
  mode_e                   mode;

  dpll_slope_limit #(.ERR_W(ERR_W), .STEP_MAX(STEP_MAX)) u_lim (
    .err_i(phase_err_i), .lim_o(lim));

  dpll_mode_sel u_mode (
    .clk_i, .rst_ni,
    .freerun_req_i,
    .hold_req_i    (ref_switch_i | impair_i),
    .hist_valid_i  (hist_valid),
    .mode_o        (mode),
    .enter_normal_o(enter_normal));

  assign hist_wr = (mode == MODE_NORMAL) && frame_tick_i;

  dpll_freq_hist #(.FREQ_W(FREQ_W), .AVG_N_LOG(AVG_N_LOG), .GUARD(GUARD)) u_hist (
    .clk_i, .rst_ni,
    .wr_i(hist_wr), .sample_i(freq), .avg_o(hold_avg), .valid_o(hist_valid));

  dpll_loop_filter #(.ERR_W(ERR_W), .FREQ_W(FREQ_W), .KP_SHIFT(KP_SHIFT),
                     .KI_SHIFT(KI_SHIFT), .NOMINAL(NOMINAL)) u_filt (
    .clk_i, .rst_ni,
    .mode_i(mode), .tick_i(frame_tick_i), .preload_i(enter_normal),
    .lim_i(lim), .hold_avg_i(hold_avg), .freq_o(freq));

  assign freq_word_o = freq;
  assign mode_o      = mode;

  p_lim_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim <= ERR_W'(STEP_MAX)) && (lim >= -ERR_W'(STEP_MAX)));
  p_hold_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_HOLD) |-> hist_valid);
endmodule

// File: tb/dpll_mode_core_test.sv
module dpll_mode_core_test;
  localparam int FW = 28;
  localparam logic [FW-1:0] NOM = 28'h800_0000;
  localparam int STEP = 5, KP = 4, KI = 1, GUARD = 2, AVGN = 4, DEPTH = 6;

  logic clk = 0, rst_n = 0, tick = 0, fr = 0, sw = 0, imp = 0;
  logic signed [15:0] err = 0;
  logic [FW-1:0] freq;
  logic [1:0] mode;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [FW-1:0] integ_m, freq_m;
  logic [FW-1:0] hm [DEPTH];
  int fill_m = 0;
  int mode_m = 2;

  always #5 clk = ~clk;

  dpll_mode_core uut (
    .clk_i(clk), .rst_ni(rst_n), .frame_tick_i(tick), .phase_err_i(err),
    .freerun_req_i(fr), .ref_switch_i(sw), .impair_i(imp),
    .freq_word_o(freq), .mode_o(mode));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int clamp(int e);
    if (e > STEP) return STEP;
    if (e < -STEP) return -STEP;
    return e;
  endfunction

  function automatic logic [FW-1:0] avg_m();
    logic [FW+1:0] s = '0;
    for (int k = GUARD; k < DEPTH; k++) s += {2'b00, hm[k]};
    return FW'(s >> 2);
  endfunction

  function automatic int mode_of(bit f, bit h);
    if (f) return 2;
    if (h) return (fill_m == DEPTH) ? 1 : 2;
    return 0;
  endfunction

  task automatic do_tick(int e, string req);
    logic [FW-1:0] le;
    err = 16'(e); tick = 1;
    @(negedge clk);
    tick = 0;
    if (mode_m == 0) begin
      for (int k = DEPTH-1; k > 0; k--) hm[k] = hm[k-1];
      hm[0] = freq_m;
      if (fill_m < DEPTH) fill_m++;
      le = FW'(clamp(e));
      integ_m = integ_m + (le << KI);
      freq_m = integ_m + (le << KP);
    end
    chk(req, 32'(freq), 32'(freq_m));
  endtask

  task automatic set_mode(bit f, bit s, bit i, string req);
    int nm;
    fr = f; sw = s; imp = i;
    nm = mode_of(f, s | i);
    @(negedge clk);
    if (nm == 0 && mode_m != 0) integ_m = freq_m;
    mode_m = nm;
    chk({req, " mode"}, 32'(mode), 32'(mode_m));
    @(negedge clk);
    if (mode_m == 1) freq_m = avg_m();
    else if (mode_m == 2) freq_m = NOM;
    chk({req, " word"}, 32'(freq), 32'(freq_m));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4402));
    for (int k = 0; k < DEPTH; k++) hm[k] = '0;
    integ_m = NOM; freq_m = NOM;
    repeat (3) @(negedge clk);
    chk("R1 reset mode", 32'(mode), 32'd2);
    chk("R1 reset word", 32'(freq), 32'(NOM));
    rst_n = 1;
    @(negedge clk);
    // R3: holdover without history falls to free-run
    set_mode(0, 1, 0, "R3");
    // R10: ticks in free-run do not touch state
    do_tick(3, "R10 free tick");
    set_mode(0, 0, 0, "R9 enter normal");
    do_tick(0, "R9 zero first tick");
    // R4 boundaries
    do_tick(5, "R4 +max");
    do_tick(-5, "R4 -max");
    do_tick(300, "R4 clamp hi");
    do_tick(-300, "R4 clamp lo");
    do_tick(6, "R4 just over");
    // R6: idle cycles keep word
    repeat (3) @(negedge clk);
    chk("R6 no tick", 32'(freq), 32'(freq_m));
    for (int k = 0; k < 4; k++) do_tick(int'($urandom_range(24)) - 12, "R5 track");
    set_mode(0, 0, 1, "R7 holdover");
    do_tick(4, "R10 hold tick");
    set_mode(1, 1, 1, "R2 freerun prio");
    set_mode(0, 1, 0, "R7 hold again");
    set_mode(0, 0, 0, "R9 re-enter");
    do_tick(0, "R9 no step");
    for (int it = 0; it < 300; it++) begin
      int r = int'($urandom_range(9));
      if (r < 7) begin
        if (mode_m == 0) do_tick(int'($urandom_range(24)) - 12, "R5 random");
        else do_tick(int'($urandom_range(24)) - 12, "R10 random");
      end else begin
        int p = int'($urandom_range(9));
        set_mode(p == 0, p inside {1, 2}, p == 3, "R2/R11 random");
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule